// File: doc/BRIEF.md
# Clock Reconfiguration Register Bridge

This block is an AXI4-Lite slave register file that sits between software and a clock-synthesis primitive. It holds two separate active-low reset controls: one for the surrounding core and one for the primitive. It also holds an input-clock select bit and a synchronized copy of the primitive's lock flag. Software reconfigures the primitive through its dynamic reconfiguration port (DRP). It loads a control word holding a read/write select, a 12-bit DRP address and 16 bits of write data. Each such write launches one DRP access.

The bridge pulses the DRP enable for one cycle. While that access is outstanding it shows a pending flag in a read-only status word. When the primitive returns ready on a read access, the bridge captures the returned data into the same status word. The lock input is asynchronous and is resynchronized before software can see it. The primitive itself, any clock multiplexing and any decode across several primitives are left to the surrounding design.

Top module: `drp_reg_bridge`

## Requirements
- R1: While `rstN` is low and after its release, `coreRstN`, `primRstN`, `clkSel`, `drpEn`, `drpWe`, `bValid` and `rValid` are 0, and every register reads 0.
- R2: Register byte 0x40 (word 0x10): bit 0 drives `coreRstN` and bit 1 drives `primRstN`. Each output follows its bit from the clock edge that accepts the write, and the register reads back the written bits.
- R3: Register byte 0x44 (word 0x11): bit 0 drives `clkSel`, where 0 picks input one and 1 picks input two. It reads back the written value.
- R4: `lockIn` passes through two flops. Its value then appears in bit 0 of byte 0x5C and in bit 17 of byte 0x74. A read accepted on the edge after `lockIn` changes still returns the old value.
- R5: Byte 0x70 is the DRP control word: bit 28 is the read select (1 = read), bits 27:16 are the DRP address and bits 15:0 are the write data. It reads back as written, with bits 31:29 zero. `drpAddr` and `drpWdata` always show the stored fields.
- R6: A write to 0x70 while idle raises `drpEn` for exactly the one cycle after the accepting edge. In that cycle `drpWe` is the inverse of bit 28. `drpWe` is never high without `drpEn`.
- R7: Bit 16 of 0x74 (busy) is 1 from the edge that starts an access until the edge on which `drpRdy` is sampled high. At that edge it clears. `drpRdy` while idle is ignored.
- R8: On a read access, the `drpRdata` value present with `drpRdy` becomes bits 15:0 of 0x74. Write accesses and `drpRdata` values at other times leave those bits unchanged.
- R9: A write to 0x70 while busy updates the stored fields but starts no access. The pending access still completes as the type it was started with.
- R10: Writes to 0x5C, 0x74 and unmapped addresses change nothing. Unmapped addresses read 0.
- R11: `bResp` and `rResp` are always 00 (OKAY). A write is accepted only when `awValid` and `wValid` are both high and no write response is pending. `bValid` holds until `bReady`. A read is accepted only when no read response is pending, and `rValid` and `rData` hold until `rReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Synchronous active-low reset |
| awAddr | input | 16 | Write address (byte) |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address accepted |
| wData | input | 32 | Write data |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| bResp | output | 2 | Write response, always OKAY |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response taken |
| arAddr | input | 16 | Read address (byte) |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address accepted |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response, always OKAY |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data taken |
| coreRstN | output | 1 | Core reset, low holds the core in reset |
| primRstN | output | 1 | Primitive reset, low holds the primitive in reset |
| clkSel | output | 1 | Input clock select for the primitive |
| lockIn | input | 1 | Asynchronous lock flag from the primitive |
| drpEn | output | 1 | DRP enable pulse |
| drpWe | output | 1 | DRP write enable |
| drpAddr | output | 12 | DRP address |
| drpWdata | output | 16 | DRP write data |
| drpRdata | input | 16 | DRP read data |
| drpRdy | input | 1 | DRP ready |

## Verification
The assertions check the following on every cycle:
- the enable is only ever a single-cycle pulse, and write-enable appears only alongside it;
- no enable pulse follows a cycle in which an access was already pending;
- both responses are OKAY, and each stays held until its ready;
- the core reset output moves only after an accepted write.

The bench's scenarios are needed for the behaviour that depends on data:
- the lock value arriving exactly two edges late;
- read data captured only with ready;
- a mid-flight control write that changes the stored fields but not the access type;
- read-only and unmapped writes leaving all visible state untouched.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = ADDR_W - 2;
  localparam int DRP_AW  = 12;
  localparam int DRP_DW  = 16;

  localparam logic [IDX_W-1:0] IDX_RST  = IDX_W'('h10);
  localparam logic [IDX_W-1:0] IDX_SEL  = IDX_W'('h11);
  localparam logic [IDX_W-1:0] IDX_LOCK = IDX_W'('h17);
  localparam logic [IDX_W-1:0] IDX_DRPC = IDX_W'('h1C);
  localparam logic [IDX_W-1:0] IDX_DRPS = IDX_W'('h1D);

  localparam int RDSEL_BIT = 28;
  localparam int ADDR_LSB  = 16;
  localparam int BUSY_BIT  = 16;
  localparam int LOCK_BIT  = 17;

  typedef struct packed {
    logic              wrRst;
    logic              wrSel;
    logic              wrDrp;
    logic [DATA_W-1:0] wrData;
  } regStrobe_t;
endpackage

// File: rtl/drp_lock_sync.sv
module drp_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/drp_bridge_ctrl.sv
module drp_bridge_ctrl
  import drp_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic              wValid,
  output logic              wReady,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [DATA_W-1:0] rData,
  output logic              rValid,
  input  logic              rReady,
  output regStrobe_t        strobe,
  output logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] rdWord
);
  logic             wrAcc;
  logic             rdAcc;
  logic [IDX_W-1:0] wrIdx;

  assign wrAcc   = awValid && wValid && !bValid;
  assign awReady = wrAcc;
  assign wReady  = wrAcc;
  assign arReady = !rValid;
  assign rdAcc   = arValid && !rValid;
  assign wrIdx   = awAddr[ADDR_W-1:2];
  assign rdIdx   = arAddr[ADDR_W-1:2];

  always_comb begin
    strobe.wrRst  = wrAcc && (wrIdx == IDX_RST);
    strobe.wrSel  = wrAcc && (wrIdx == IDX_SEL);
    strobe.wrDrp  = wrAcc && (wrIdx == IDX_DRPC);
    strobe.wrData = wData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValid <= 1'b0;
    end else if (wrAcc) begin
      bValid <= 1'b1;
    end else if (bReady) begin
      bValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValid <= 1'b0;
      rData  <= '0;
    end else if (rdAcc) begin
      rValid <= 1'b1;
      rData  <= rdWord;
    end else if (rReady) begin
      rValid <= 1'b0;
    end
  end
endmodule

// File: rtl/drp_bridge_dp.sv
module drp_bridge_dp
  import drp_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdWord,
  input  logic              lockSync,
  output logic              coreRstN,
  output logic              primRstN,
  output logic              clkSel,
  output logic              drpEn,
  output logic              drpWe,
  output logic [DRP_AW-1:0] drpAddr,
  output logic [DRP_DW-1:0] drpWdata,
  input  logic [DRP_DW-1:0] drpRdata,
  input  logic              drpRdy,
  output logic              busy
);
  logic              rdSel;
  logic              txIsRead;
  logic              start;
  logic [DRP_DW-1:0] rdCapture;

  assign start = strobe.wrDrp && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreRstN <= 1'b0;
      primRstN <= 1'b0;
      clkSel   <= 1'b0;
      rdSel    <= 1'b0;
      drpAddr  <= '0;
      drpWdata <= '0;
    end else begin
      if (strobe.wrRst) begin
        coreRstN <= strobe.wrData[0];
        primRstN <= strobe.wrData[1];
      end
      if (strobe.wrSel) clkSel <= strobe.wrData[0];
      if (strobe.wrDrp) begin
        rdSel    <= strobe.wrData[RDSEL_BIT];
        drpAddr  <= strobe.wrData[ADDR_LSB +: DRP_AW];
        drpWdata <= strobe.wrData[DRP_DW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      txIsRead  <= 1'b0;
      drpEn     <= 1'b0;
      drpWe     <= 1'b0;
      rdCapture <= '0;
    end else begin
      drpEn <= start;
      drpWe <= start && !strobe.wrData[RDSEL_BIT];
      if (busy && drpRdy) begin
        busy <= 1'b0;
        if (txIsRead) rdCapture <= drpRdata;
      end
      if (start) begin
        busy     <= 1'b1;
        txIsRead <= strobe.wrData[RDSEL_BIT];
      end
    end
  end

  always_comb begin
    rdWord = '0;
    unique case (rdIdx)
      IDX_RST:  rdWord[1:0] = {primRstN, coreRstN};
      IDX_SEL:  rdWord[0]   = clkSel;
      IDX_LOCK: rdWord[0]   = lockSync;
      IDX_DRPC: begin
        rdWord[RDSEL_BIT]             = rdSel;
        rdWord[ADDR_LSB +: DRP_AW]    = drpAddr;
        rdWord[DRP_DW-1:0]            = drpWdata;
      end
      IDX_DRPS: begin
        rdWord[LOCK_BIT]   = lockSync;
        rdWord[BUSY_BIT]   = busy;
        rdWord[DRP_DW-1:0] = rdCapture;
      end
      default: rdWord = '0;
    endcase
  end
endmodule

// File: rtl/drp_reg_bridge.sv
module drp_reg_bridge
  import drp_bridge_pkg::*;
#(
  parameter int LOCK_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic              wValid,
  output logic              wReady,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rValid,
  input  logic              rReady,
  output logic              coreRstN,
  output logic              primRstN,
  output logic              clkSel,
  input  logic              lockIn,
  output logic              drpEn,
  output logic              drpWe,
  output logic [DRP_AW-1:0] drpAddr,
  output logic [DRP_DW-1:0] drpWdata,
  input  logic [DRP_DW-1:0] drpRdata,
  input  logic              drpRdy
);
  regStrobe_t        strobe;
  logic [IDX_W-1:0]  rdIdx;
  logic [DATA_W-1:0] rdWord;
  logic              lockSync;
  logic              busyFlag;

  assign bResp = 2'b00;
  assign rResp = 2'b00;

  drp_lock_sync #(.STAGES(LOCK_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(lockIn), .syncOut(lockSync)
  );

  drp_bridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wValid(wValid), .wReady(wReady),
    .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rValid(rValid), .rReady(rReady),
    .strobe(strobe), .rdIdx(rdIdx), .rdWord(rdWord)
  );

  drp_bridge_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(rdIdx), .rdWord(rdWord),
    .lockSync(lockSync), .coreRstN(coreRstN), .primRstN(primRstN),
    .clkSel(clkSel), .drpEn(drpEn), .drpWe(drpWe), .drpAddr(drpAddr),
    .drpWdata(drpWdata), .drpRdata(drpRdata), .drpRdy(drpRdy), .busy(busyFlag)
  );
endmodule

// File: rtl/drp_bridge_chk.sv
module drp_bridge_chk (
  input logic        clk,
  input logic        rstN,
  input logic        awValid,
  input logic        awReady,
  input logic        bValid,
  input logic        bReady,
  input logic [1:0]  bResp,
  input logic        rValid,
  input logic        rReady,
  input logic [31:0] rData,
  input logic [1:0]  rResp,
  input logic        drpEn,
  input logic        drpWe,
  input logic        busyFlag,
  input logic        coreRstN
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    drpEn |=> !drpEn);
  a_r6_we_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    drpWe |-> drpEn);
  a_r7_busy_with_en: assert property (@(posedge clk) disable iff (!rstN)
    drpEn |-> busyFlag);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |=> !drpEn);
  a_r11_bresp_okay: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> bResp == 2'b00);
  a_r11_rresp_okay: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> rResp == 2'b00);
  a_r11_b_hold: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid);
  a_r11_r_hold: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid && $stable(rData));
  a_r11_no_accept_pending: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> !awReady);
  a_r2_rst_by_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(coreRstN) |-> $past(awValid && awReady));
endmodule

bind drp_reg_bridge drp_bridge_chk u_chk (
  .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady),
  .bValid(bValid), .bReady(bReady), .bResp(bResp),
  .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp),
  .drpEn(drpEn), .drpWe(drpWe), .busyFlag(busyFlag), .coreRstN(coreRstN)
);

// File: tb/tb_drp_reg_bridge.sv
module tb_drp_reg_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] awAddr = 0, arAddr = 0;
  logic        awValid = 0, wValid = 0, bReady = 0, arValid = 0, rReady = 0;
  logic [31:0] wData = 0;
  logic        awReady, wReady, bValid, arReady, rValid;
  logic [1:0]  bResp, rResp;
  logic [31:0] rData;
  logic        coreRstN, primRstN, clkSel, drpEn, drpWe;
  logic        lockIn = 0;
  logic [11:0] drpAddr;
  logic [15:0] drpWdata;
  logic [15:0] drpRdata = 16'h5A5A;
  logic        drpRdy = 0;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drp_reg_bridge dut (
    .clk(clk), .rstN(rstN), .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wValid(wValid), .wReady(wReady), .bResp(bResp), .bValid(bValid),
    .bReady(bReady), .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .coreRstN(coreRstN), .primRstN(primRstN), .clkSel(clkSel), .lockIn(lockIn),
    .drpEn(drpEn), .drpWe(drpWe), .drpAddr(drpAddr), .drpWdata(drpWdata),
    .drpRdata(drpRdata), .drpRdy(drpRdy)
  );

  // DRP responder model
  logic [15:0] mem [16];
  int rspDelay = 3;
  int rspCnt = 0;
  bit rspWe;
  logic [3:0] rspA;
  initial for (int i = 0; i < 16; i++) mem[i] = 16'h0100 + 16'(i);

  always @(negedge clk) begin
    drpRdy = 0;
    drpRdata = 16'h5A5A;
    if (rspCnt == 1) begin
      drpRdy = 1;
      drpRdata = rspWe ? 16'hDEAD : mem[rspA];
    end
    if (rspCnt > 0) rspCnt--;
    if (drpEn) begin
      rspCnt = rspDelay;
      rspWe = drpWe;
      rspA = drpAddr[3:0];
      if (drpWe) mem[drpAddr[3:0]] = drpWdata;
    end
  end

  // Behavioural reference model
  bit mCore, mPrim, mSel, mRdSel, mBusy, mTxRd, mEn, mWe, mB, mR, mL1, mL2;
  logic [11:0] mAddr;
  logic [15:0] mWd, mRd;
  logic [31:0] mRData;

  function automatic logic [31:0] modelRead(input logic [13:0] idx);
    case (idx)
      14'h10: return {30'b0, mPrim, mCore};
      14'h11: return {31'b0, mSel};
      14'h17: return {31'b0, mL2};
      14'h1C: return {3'b0, mRdSel, mAddr, mWd};
      14'h1D: return {14'b0, mL2, mBusy, mRd};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit wrAcc, rdAcc, start;
    logic [13:0] wi;
    if (!rstN) begin
      mCore = 0; mPrim = 0; mSel = 0; mRdSel = 0; mBusy = 0; mTxRd = 0;
      mEn = 0; mWe = 0; mB = 0; mR = 0; mL1 = 0; mL2 = 0;
      mAddr = 0; mWd = 0; mRd = 0; mRData = 0;
    end else begin
      wrAcc = awValid && wValid && !mB;
      rdAcc = arValid && !mR;
      wi = awAddr[15:2];
      if (rdAcc) mRData = modelRead(arAddr[15:2]);
      mR = rdAcc ? 1'b1 : (rReady ? 1'b0 : mR);
      mB = wrAcc ? 1'b1 : (bReady ? 1'b0 : mB);
      start = wrAcc && wi == 14'h1C && !mBusy;
      if (mBusy && drpRdy) begin
        mBusy = 0;
        if (mTxRd) mRd = drpRdata;
      end
      if (start) begin
        mBusy = 1;
        mTxRd = wData[28];
      end
      mEn = start;
      mWe = start && !wData[28];
      if (wrAcc) begin
        case (wi)
          14'h10: begin mCore = wData[0]; mPrim = wData[1]; end
          14'h11: mSel = wData[0];
          14'h1C: begin mRdSel = wData[28]; mAddr = wData[27:16]; mWd = wData[15:0]; end
          default: ;
        endcase
      end
      mL2 = mL1;
      mL1 = lockIn;
    end
  end

  // Per-cycle comparison (R2, R3, R5, R6, R11)
  always @(negedge clk) begin
    if (rstN && !done) begin
      compared++;
      if ({coreRstN, primRstN, clkSel, drpEn, drpWe, drpAddr, drpWdata, bValid, rValid}
          !== {mCore, mPrim, mSel, mEn, mWe, mAddr, mWd, mB, mR} ||
          (rValid && rData !== mRData)) begin
        mismatched++;
        $display("FAIL R2/R3/R5/R6/R11 cycle model t=%0t act=%b_%b_%b_%b_%b_%h_%h_%b_%b rd=%h exp=%b_%b_%b_%b_%b_%h_%h_%b_%b rd=%h",
          $time, coreRstN, primRstN, clkSel, drpEn, drpWe, drpAddr, drpWdata, bValid, rValid, rData,
          mCore, mPrim, mSel, mEn, mWe, mAddr, mWd, mB, mR, mRData);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic axiWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    awAddr = a; wData = d; awValid = 1; wValid = 1; bReady = 1;
    @(negedge clk);
    awValid = 0; wValid = 0;
  endtask

  task automatic axiRead(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    arAddr = a; arValid = 1; rReady = 0;
    @(negedge clk);
    arValid = 0;
    d = rData;
    chk("R11 rResp", {30'b0, rResp}, 0);
    rReady = 1;
    @(negedge clk);
    rReady = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rd;

  initial begin
    idle(2);
    chk("R1 outputs in reset", {27'b0, coreRstN, primRstN, clkSel, drpEn, bValid}, 0);
    rstN = 1;
    idle(1);
    chk("R1 outputs after reset", {26'b0, coreRstN, primRstN, clkSel, drpEn, drpWe, rValid}, 0);
    axiRead(16'h0040, rd); chk("R1 reset reg 0x40", rd, 0);
    axiRead(16'h0070, rd); chk("R1 reset reg 0x70", rd, 0);
    axiRead(16'h0074, rd); chk("R1 reset reg 0x74", rd, 0);

    // R2
    axiWrite(16'h0040, 32'h1);
    chk("R2 core released", {30'b0, primRstN, coreRstN}, 32'h1);
    axiRead(16'h0040, rd); chk("R2 readback 1", rd, 32'h1);
    axiWrite(16'h0040, 32'h2);
    chk("R2 prim only", {30'b0, primRstN, coreRstN}, 32'h2);
    axiWrite(16'h0040, 32'h3);
    axiRead(16'h0040, rd); chk("R2 readback 3", rd, 32'h3);

    // R3
    axiWrite(16'h0044, 32'h1);
    chk("R3 clkSel", {31'b0, clkSel}, 1);
    axiRead(16'h0044, rd); chk("R3 readback", rd, 1);

    // R4: read accepted on the edge right after the change still sees old value
    @(negedge clk);
    lockIn = 1; arAddr = 16'h005C; arValid = 1;
    @(negedge clk);
    arValid = 0;
    chk("R4 lock not yet visible", rData, 0);
    rReady = 1; @(negedge clk); rReady = 0;
    idle(2);
    axiRead(16'h005C, rd); chk("R4 lock word 0x5C", rd, 1);
    axiRead(16'h0074, rd); chk("R4 lock bit 17", rd, 32'h0002_0000);

    // R5 / R6: write access
    axiWrite(16'h0070, 32'h0005_BEEF);
    chk("R6 en/we on write access", {30'b0, drpEn, drpWe}, 32'h3);
    chk("R5 drp addr/data", {4'b0, drpAddr, drpWdata}, 32'h0005_BEEF);
    @(negedge clk);
    chk("R6 enable one cycle", {31'b0, drpEn}, 0);
    idle(5);
    axiRead(16'h0070, rd); chk("R5 control readback", rd, 32'h0005_BEEF);

    // R7 / R8: read access
    axiWrite(16'h0070, 32'h1005_0000);
    chk("R6 read access we low", {30'b0, drpEn, drpWe}, 32'h2);
    axiRead(16'h0074, rd); chk("R7 busy set", rd, 32'h0003_0000);
    idle(5);
    axiRead(16'h0074, rd); chk("R8 read data captured", rd, 32'h0002_BEEF);
    axiWrite(16'h0070, 32'h0006_1234);
    idle(6);
    axiRead(16'h0074, rd); chk("R8 write access keeps data", rd, 32'h0002_BEEF);
    rspDelay = 0;
    idle(1);

    // R7: stray ready while idle is ignored (responder off, manual ready)
    @(negedge clk);
    drpRdy = 1; drpRdata = 16'h7777;
    @(negedge clk);
    axiRead(16'h0074, rd); chk("R7 idle ready ignored", rd, 32'h0002_BEEF);

    // R9: write while busy
    rspDelay = 10;
    axiWrite(16'h0070, 32'h1006_0000);
    axiWrite(16'h0070, 32'h0007_4321);
    chk("R9 no new enable", {31'b0, drpEn}, 0);
    chk("R9 fields updated", {4'b0, drpAddr, drpWdata}, 32'h0007_4321);
    axiRead(16'h0074, rd); chk("R9 still busy", {15'b0, rd[16:0]}, 32'h0001_BEEF);
    idle(10);
    axiRead(16'h0074, rd); chk("R9 first access completes as read", rd, 32'h0002_1234);
    axiRead(16'h0070, rd); chk("R9 control holds new value", rd, 32'h0007_4321);
    rspDelay = 3;

    // R10
    axiWrite(16'h0074, 32'hFFFF_FFFF);
    axiWrite(16'h005C, 32'h0);
    axiWrite(16'h0048, 32'h1);
    axiRead(16'h0074, rd); chk("R10 status unchanged", rd, 32'h0002_1234);
    axiRead(16'h005C, rd); chk("R10 lock unchanged", rd, 1);
    axiRead(16'h0048, rd); chk("R10 unmapped reads 0", rd, 0);
    axiRead(16'h0140, rd); chk("R10 unmapped 0x140", rd, 0);
    axiRead(16'h0044, rd); chk("R10 neighbour unchanged", rd, 1);
    chk("R10 outputs unchanged", {29'b0, coreRstN, primRstN, clkSel}, 32'h7);

    // R11: handshake rules
    @(negedge clk);
    awAddr = 16'h0044; awValid = 1; wValid = 0; wData = 0;
    #1 chk("R11 no accept without wValid", {31'b0, awReady}, 0);
    wValid = 1; bReady = 0;
    @(negedge clk);
    chk("R11 bValid up", {31'b0, bValid}, 1);
    chk("R11 bResp okay", {30'b0, bResp}, 0);
    awAddr = 16'h0040; wData = 0;
    #1 chk("R11 no accept while response pending", {31'b0, awReady}, 0);
    @(negedge clk);
    awValid = 0; wValid = 0;
    chk("R11 bValid held", {31'b0, bValid}, 1);
    chk("R11 pending write not taken", {31'b0, coreRstN}, 1);
    bReady = 1;
    @(negedge clk);
    chk("R11 bValid dropped", {31'b0, bValid}, 0);
    @(negedge clk);
    arAddr = 16'h0040; arValid = 1; rReady = 0;
    @(negedge clk);
    arAddr = 16'h0044;
    @(negedge clk);
    chk("R11 rValid held", {31'b0, rValid}, 1);
    chk("R11 rData held", rData, 32'h3);
    arValid = 0; rReady = 1;
    @(negedge clk);
    rReady = 0;
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule